// File: doc/BRIEF.md
# Indirect Per-Line Register Bank with Transmit Silos

This block holds the per-line state of an eight-line serial controller and gives the host access to it through a single indirect window. A write to the control/status word (CSR) selects a line and one of four per-line registers. Later window reads and writes then reach the chosen register of the chosen line: the transmit buffer (a push into that line's character silo, with its fill count read back), the line control and modem control bytes, or the two 16-bit DMA parameter words, which are held as storage here.

Each line owns a 32-entry first-in first-out transmit silo. While a line's transmit enable is set, the serialiser downstream takes one character per `tx_ready` strobe. When a line's silo runs empty by draining, that line raises a pending transmit-done event. The CSR reports pending events one line at a time, lowest line first, and a CSR read acknowledges the line it reported. Serialisation and the DMA engine sit outside this block.

Top module: `txl_bank`

## Requirements
- R1: After synchronous reset the CSR reads 0x0000, every silo count reads 0, `tx_irq` is 0 and `tx_valid` is all zero.
- R2: `csr_wr` stores `wdata[4:0]` as the indirect address and `wdata[14]` as the interrupt enable. Bits 2:0 select the line and bits 4:3 select the register: 00 transmit buffer, 01 line control, 10 DMA address, 11 character count. A read strobe (`csr_rd` or `win_rd`) puts its word on `rdata` one cycle later, and `csr_rd` has priority. The CSR reads {bit15 flag, bit14 enable, bit13 memory error, 12:11 zero, 10:8 reported line, 7:5 zero, 4:0 address}.
- R3: With the transmit buffer selected, a window write with `be[0]` pushes `wdata[7:0]` into the selected line's silo. A window read returns the fill count (0 to 32) in bits 7:0 and that line's `rx_modem` byte in bits 15:8.
- R4: A push into a silo already holding 32 characters is ignored: the count stays 32 and the extra character is never sent.
- R5: On a `tx_ready[i]` strobe, with line control bit 0 (transmit enable) set and the silo not empty, the line sends its oldest character. `tx_valid[i]` is high with the character on `tx_data[8*i+:8]` in the following cycle. With transmit enable clear, the strobe does nothing.
- R6: A line-control write with `be[0]` and `wdata[4]` set empties the selected silo. Bit 4 always reads back as 0, and the flush does not raise an event.
- R7: Line control bits 0,1,2,3,5 (`be[0]`) and the modem control byte in bits 15:8 (`be[1]`) are stored per line and read back. The DMA address and count words are stored per line with per-byte enables.
- R8: When a drain empties a line's silo, that line becomes pending. CSR bit 15 is set, bits 10:8 name the lowest pending line, and `tx_irq` equals bit 15 AND the interrupt enable.
- R9: A CSR read while bit 15 is set clears the reported line's pending state, so the next read reports the next lowest pending line.
- R10: A push and a drain on the same line in the same cycle leave the count unchanged. If the count was 1, no event is raised.
- R11: CSR bit 13 follows the `dma_nxm` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe for the CSR |
| csr_rd | input | 1 | Read strobe for the CSR (acknowledges the reported line) |
| win_wr | input | 1 | Write strobe for the indirect window |
| win_rd | input | 1 | Read strobe for the indirect window |
| be | input | 2 | Byte enables for window writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rx_modem | input | 8*NLINES | Receive modem status byte per line |
| dma_nxm | input | 1 | Non-existent memory error from the DMA side |
| tx_ready | input | NLINES | Per-line request for the next character |
| tx_valid | output | NLINES | Per-line character-sent pulse |
| tx_data | output | 8*NLINES | Per-line sent character |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
Two functions can land in the same cycle: a host push into a silo and a drain from the same silo. The bench holds a window push and a `tx_ready` strobe in one clock on a line that holds exactly one character. It then expects the old character to be sent, the count to stay at 1, and the CSR to show no event. A following plain drain must then raise the event for that line. A second overlap is a drain that empties several lines at once. The bench judges that case by the order of the lines reported over successive acknowledging CSR reads.

// File: rtl/txl_pkg.sv
package txl_pkg;
  typedef enum logic [1:0] {
    SEL_TBUF = 2'b00,
    SEL_LCTL = 2'b01,
    SEL_DADR = 2'b10,
    SEL_DCNT = 2'b11
  } win_sel_e;

  localparam logic [7:0] LCTL_MASK = 8'h2F;
  localparam int         LCTL_TE   = 0;
  localparam int         LCTL_FLSH = 4;
endpackage

// File: rtl/txl_silo.sv
module txl_silo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] pdata,
  input  logic          flush,
  input  logic          ready,
  input  logic          en,
  output logic [CW-1:0] count,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          drained
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && !flush && (count != CW'(DEPTH));
  assign do_pop  = ready && en && !flush && (count != '0);
  assign drained = do_pop && !do_push && (count == CW'(1));

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; count <= '0;
      out_valid <= 1'b0; out_data <= '0;
    end else begin
      out_valid <= do_pop;
      if (do_pop) out_data <= mem[rp];
      if (flush) begin
        wp <= '0; rp <= '0; count <= '0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        count <= count + CW'(do_push) - CW'(do_pop);
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R3
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH) && push && !ready && !flush) |=> $stable(count)); // R4
  AST_NO_TE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    !en |=> !out_valid); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0)); // R6
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (push && ready && en && !flush && count != '0 && count != CW'(DEPTH))
      |=> $stable(count)); // R10
endmodule

// File: rtl/txl_done_arb.sv
module txl_done_arb #(
  parameter int NLINES = 8,
  localparam int LW    = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] set,
  input  logic              ack,
  output logic              flag,
  output logic [LW-1:0]     line
);
  logic [NLINES-1:0] pending;
  logic [NLINES-1:0] clr_mask;

  always_comb begin
    line = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (pending[i]) line = LW'(i);
    end
  end

  assign flag = |pending;

  always_comb begin
    clr_mask = '0;
    if (ack && flag) clr_mask[line] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= (pending & ~clr_mask) | set;
  end

  AST_SET_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> flag); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack && flag && !set[line]) |=> !pending[$past(line)]); // R9
endmodule

// File: rtl/txl_bank.sv
module txl_bank
  import txl_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int DEPTH  = 32,
  localparam int LW    = $clog2(NLINES),
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csr_wr,
  input  logic                csr_rd,
  input  logic                win_wr,
  input  logic                win_rd,
  input  logic [1:0]          be,
  input  logic [15:0]         wdata,
  output logic [15:0]         rdata,
  input  logic [8*NLINES-1:0] rx_modem,
  input  logic                dma_nxm,
  input  logic [NLINES-1:0]   tx_ready,
  output logic [NLINES-1:0]   tx_valid,
  output logic [8*NLINES-1:0] tx_data,
  output logic                tx_irq
);
  logic [4:0]  iad;
  logic        tie;
  logic [7:0]  lctl_q [NLINES];
  logic [7:0]  mctl_q [NLINES];
  logic [15:0] dadr_q [NLINES];
  logic [15:0] dcnt_q [NLINES];
  logic [CW-1:0] cnt_w [NLINES];
  logic [NLINES-1:0] done_set;
  logic        ev_flag;
  logic [LW-1:0] ev_line;
  logic [LW-1:0] ln;
  win_sel_e    sel;
  logic [15:0] csr_word, win_word;

  assign ln  = iad[LW-1:0];
  assign sel = win_sel_e'(iad[4:3]);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic hit;
    assign hit = win_wr && be[0] && (ln == LW'(i));
    txl_silo #(.DEPTH(DEPTH), .DW(8)) u_silo (
      .clk(clk), .rst(rst),
      .push(hit && sel == SEL_TBUF),
      .pdata(wdata[7:0]),
      .flush(hit && sel == SEL_LCTL && wdata[LCTL_FLSH]),
      .ready(tx_ready[i]),
      .en(lctl_q[i][LCTL_TE]),
      .count(cnt_w[i]),
      .out_valid(tx_valid[i]),
      .out_data(tx_data[8*i +: 8]),
      .drained(done_set[i])
    );
  end

  txl_done_arb #(.NLINES(NLINES)) u_arb (
    .clk(clk), .rst(rst), .set(done_set), .ack(csr_rd),
    .flag(ev_flag), .line(ev_line)
  );

  assign tx_irq = ev_flag && tie;

  always_ff @(posedge clk) begin
    if (rst) begin
      iad <= '0;
      tie <= 1'b0;
      for (int i = 0; i < NLINES; i++) begin
        lctl_q[i] <= '0; mctl_q[i] <= '0;
        dadr_q[i] <= '0; dcnt_q[i] <= '0;
      end
    end else begin
      if (csr_wr) begin
        iad <= wdata[4:0];
        tie <= wdata[14];
      end
      if (win_wr) begin
        case (sel)
          SEL_LCTL: begin
            if (be[0]) lctl_q[ln] <= wdata[7:0] & LCTL_MASK;
            if (be[1]) mctl_q[ln] <= wdata[15:8];
          end
          SEL_DADR: begin
            if (be[0]) dadr_q[ln][7:0]  <= wdata[7:0];
            if (be[1]) dadr_q[ln][15:8] <= wdata[15:8];
          end
          SEL_DCNT: begin
            if (be[0]) dcnt_q[ln][7:0]  <= wdata[7:0];
            if (be[1]) dcnt_q[ln][15:8] <= wdata[15:8];
          end
          default: ;
        endcase
      end
    end
  end

  assign csr_word = {ev_flag, tie, dma_nxm, 2'b00, 3'(ev_line), 3'b000, iad};

  always_comb begin
    case (sel)
      SEL_TBUF: win_word = {rx_modem[8*ln +: 8], 8'(cnt_w[ln])};
      SEL_LCTL: win_word = {mctl_q[ln], lctl_q[ln]};
      SEL_DADR: win_word = dadr_q[ln];
      default:  win_word = dcnt_q[ln];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (csr_rd) rdata <= csr_word;
    else if (win_rd) rdata <= win_word;
  end

  AST_FLUSH_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (win_wr && be[0] && sel == SEL_LCTL) |=> !lctl_q[$past(ln)][LCTL_FLSH]); // R6
endmodule

// File: tb/txl_bank_bench.sv
module txl_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic csr_wr = 0, csr_rd = 0, win_wr = 0, win_rd = 0;
  logic [1:0] be = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [8*NL-1:0] rx_modem = '0;
  logic dma_nxm = 0;
  logic [NL-1:0] tx_ready = '0;
  logic [NL-1:0] tx_valid;
  logic [8*NL-1:0] tx_data;
  logic tx_irq;

  int tests = 0, fails = 0;
  logic tie_g = 0;
  logic [4:0] iad_g = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txl_bank #(.NLINES(NL), .DEPTH(32)) u_txl_bank (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_rd(csr_rd), .win_wr(win_wr),
    .win_rd(win_rd), .be(be), .wdata(wdata), .rdata(rdata), .rx_modem(rx_modem),
    .dma_nxm(dma_nxm), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_w(input logic [15:0] v);
    @(negedge clk); csr_wr = 1; wdata = v;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic sel(input logic [1:0] s, input int line);
    iad_g = {s, 3'(line)};
    csr_w({1'b0, tie_g, 9'b0, iad_g});
  endtask

  task automatic win_w(input logic [1:0] b, input logic [15:0] v);
    @(negedge clk); win_wr = 1; be = b; wdata = v;
    @(negedge clk); win_wr = 0; be = 0;
  endtask

  task automatic rd_csr(output logic [15:0] v);
    @(negedge clk); csr_rd = 1;
    @(negedge clk); csr_rd = 0; v = rdata;
  endtask

  task automatic rd_win(output logic [15:0] v);
    @(negedge clk); win_rd = 1;
    @(negedge clk); win_rd = 0; v = rdata;
  endtask

  task automatic push(input int line, input logic [7:0] c);
    sel(2'b00, line);
    win_w(2'b01, {8'h00, c});
  endtask

  task automatic set_lctl(input int line, input logic [7:0] v);
    sel(2'b01, line);
    win_w(2'b01, {8'h00, v});
  endtask

  task automatic count_of(input int line, output logic [15:0] v);
    sel(2'b00, line);
    rd_win(v);
  endtask

  task automatic pulse(input logic [NL-1:0] m);
    @(negedge clk); tx_ready = m;
    @(negedge clk); tx_ready = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
    rd_csr(v); chk("R1 csr", v, 16'h0000);
    rd_win(v); chk("R1 count line0", v[7:0], 0);

    // R2 select and enable
    tie_g = 1; sel(2'b11, 5);
    rd_csr(v); chk("R2 csr word", v, 16'h401D);

    // R11 memory error bit
    dma_nxm = 1;
    rd_csr(v); chk("R11 nxm set", v, 16'h601D);
    dma_nxm = 0;
    rd_csr(v); chk("R11 nxm clear", v, 16'h401D);

    // R7 per-line storage
    for (int l = 0; l < NL; l++) begin
      sel(2'b01, l); win_w(2'b11, {8'hC0 | 8'(l), 8'hEF});
      sel(2'b10, l); win_w(2'b11, 16'h1234 + 16'(l)); win_w(2'b10, 16'hAB00);
      sel(2'b11, l); win_w(2'b11, 16'h5A00 | 16'(l)); win_w(2'b01, 16'h00EE);
    end
    for (int l = 0; l < NL; l++) begin
      sel(2'b01, l); rd_win(v); chk("R7 lctl/mctl", v, {8'hC0 | 8'(l), 8'h2F});
      sel(2'b10, l); rd_win(v); chk("R7 dma addr", v, {8'hAB, 8'h34 + 8'(l)});
      sel(2'b11, l); rd_win(v); chk("R7 dma count", v, 16'h5AEE);
    end
    for (int l = 0; l < NL; l++) begin
      sel(2'b01, l); win_w(2'b11, 16'h0000);
    end

    // R3 / R4 fill line 3 beyond capacity
    rx_modem[3*8 +: 8] = 8'h96;
    for (int k = 0; k < 33; k++) begin
      push(3, 8'h40 + 8'(k));
      rd_win(v);
      chk("R3/R4 count", v, {8'h96, 8'(k < 32 ? k + 1 : 32)});
    end

    // R5 transmit enable clear: strobe ignored
    pulse(8'h08);
    chk("R5 no send when disabled", tx_valid, 0);
    count_of(3, v); chk("R5 count kept", v[7:0], 32);

    // R5 drain in order, R4 extra char never appears
    set_lctl(3, 8'h01);
    for (int k = 0; k < 32; k++) begin
      pulse(8'h08);
      chk("R5 valid", tx_valid, 8'h08);
      chk("R5/R4 data", tx_data[3*8 +: 8], 8'h40 + 8'(k));
    end
    pulse(8'h08);
    chk("R5 empty no send", tx_valid, 0);
    chk("R8 irq line3", tx_irq, 1);
    rd_csr(v); chk("R8 csr line3", v, 16'hC300 | 16'(iad_g));
    rd_csr(v); chk("R9 ack clears", v, 16'h4000 | 16'(iad_g));
    chk("R8 irq low", tx_irq, 0);
    set_lctl(3, 8'h00);

    // R8 / R9 several lines at once
    push(6, 8'hA6); push(2, 8'hA2); push(5, 8'hA5);
    set_lctl(6, 8'h01); set_lctl(2, 8'h01); set_lctl(5, 8'h01);
    pulse(8'h64);
    chk("R5 multi valid", tx_valid, 8'h64);
    chk("R5 line2 data", tx_data[2*8 +: 8], 8'hA2);
    chk("R8 irq multi", tx_irq, 1);
    rd_csr(v); chk("R9 first line2", v[15:8], 8'hC2);
    rd_csr(v); chk("R9 next line5", v[15:8], 8'hC5);
    rd_csr(v); chk("R9 next line6", v[15:8], 8'hC6);
    rd_csr(v); chk("R9 none left", v[15], 0);

    // R10 push and drain together at count 1
    push(0, 8'h11);
    set_lctl(0, 8'h01);
    sel(2'b00, 0);
    @(negedge clk); win_wr = 1; be = 2'b01; wdata = 16'h0022; tx_ready = 8'h01;
    @(negedge clk); win_wr = 0; be = 0; tx_ready = 0;
    chk("R10 sent old", tx_data[7:0], 8'h11);
    chk("R10 valid", tx_valid, 8'h01);
    rd_win(v); chk("R10 count held", v[7:0], 1);
    rd_csr(v); chk("R10 no event", v[15], 0);
    pulse(8'h01);
    chk("R10 second char", tx_data[7:0], 8'h22);
    rd_csr(v); chk("R8 line0 event", v[15:8], 8'hC0);

    // R6 flush
    for (int k = 0; k < 10; k++) push(4, 8'h80 + 8'(k));
    count_of(4, v); chk("R6 before flush", v[7:0], 10);
    set_lctl(4, 8'h11);
    count_of(4, v); chk("R6 flushed", v[7:0], 0);
    sel(2'b01, 4); rd_win(v); chk("R6 flush bit reads 0", v[7:0], 8'h01);
    rd_csr(v); chk("R6 no event", v[15], 0);
    push(4, 8'h77);
    pulse(8'h10);
    chk("R6 after flush data", tx_data[4*8 +: 8], 8'h77);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule